// File: doc/BRIEF.md
# Dual-Mode Video Output Formatter

This block turns a pixel stream of 4-bit red, green and blue channels with horizontal and vertical sync and blank flags into the words on an 8-pin video bus. Every pixel lasts a fixed number of video clocks; four by default. An internal phase counter paces the stream. On the last clock of each pixel the block raises `pix_next` and latches the inputs that the upstream pixel generator presents. It then shows that pixel on the pins during the next pixel period.

The `mode_ser` input picks the pin format. In the direct format, the pins feed a resistor ladder with the upper two bits of each colour and the two sync levels, held for the whole pixel. In the serial format, each colour pin carries its channel one bit per clock, most significant bit first. A fourth pin carries the sync and blank flags in the same way. Three further pins give an external deserializer a bit clock, a capture strobe and a frame interrupt.

The upstream timing generator sends each 240-line source row twice. It raises `dbl_row` for the repeat. On the first pass the block stores each visible pixel in a line buffer, by column. On the repeat it replays the buffer and ignores the colour input. The replay can be darkened to half intensity.

Top module: `vfmt_top`

## Requirements
- R1: `pix_next` is high on exactly one clock in every PIX_CLKS (4) clocks, beginning on the fourth clock after reset release. On that clock edge the block latches the pixel inputs `pix_rgb`, sync flags, `dbl_row` and `dim_en`. The latched pixel appears on the pins from the next clock onward, for PIX_CLKS clocks.
- R2: With `mode_ser`=0, `vid_pins` = {hsync, vsync, blue[3:2], green[3:2], red[3:2]}, bit 7 down to bit 0. `pix_rgb` packs red in [3:0], green in [7:4] and blue in [11:8].
- R3: With `mode_ser`=0, `vid_pins` keeps the same value on all four clocks of a pixel.
- R4: With `mode_ser`=1, on clock k (0..3) of a pixel, pin 0 carries red bit 3-k, pin 1 green bit 3-k and pin 2 blue bit 3-k. The most significant bit goes first.
- R5: With `mode_ser`=1, pin 3 carries hsync on clock 0, vsync on clock 1, hblank on clock 2 and vblank on clock 3 of each pixel.
- R6: With `mode_ser`=1, pin 5 (capture) is high only on clock 3 of each pixel. Pin 4 (bit clock) is high on clocks 0 and 2 and low on clocks 1 and 3. Pin 7 is low.
- R7: With `mode_ser`=1, pin 6 is high for the four clocks of a pixel whose vblank is set when the pixel before it had vblank clear. It is low for every other pixel.
- R8: A pixel with hblank or vblank set carries colour value zero on the pins in both formats, whatever `pix_rgb` holds.
- R9: A visible pixel with `dbl_row`=1 shows the colour stored at its column on the last row with `dbl_row`=0. `pix_rgb` is ignored for that pixel.
- R10: When both `dbl_row` and `dim_en` are 1, each 4-bit channel of the replayed colour is shifted right by one bit.
- R11: The column index returns to 0 after any blank pixel and advances by one for each visible pixel. It stops at LINE_PIX-1, so later pixels of an over-long row share the last slot.
- R12: While `rst_n` is low the latched pixel is all zero and the phase is 0. With `mode_ser`=0 the pins read 0 and `pix_next` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Video clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_ser | input | 1 | 0 = direct 64-colour pins, 1 = serial 4096-colour pins |
| dim_en | input | 1 | Darken the replayed row |
| dbl_row | input | 1 | Current row is the repeat of the previous row |
| pix_rgb | input | 12 | Pixel colour: blue[11:8], green[7:4], red[3:0] |
| hs_in | input | 1 | Horizontal sync level |
| vs_in | input | 1 | Vertical sync level |
| hb_in | input | 1 | Horizontal blank |
| vb_in | input | 1 | Vertical blank |
| pix_next | output | 1 | Inputs are latched at the end of this clock |
| vid_pins | output | 8 | Video output bus |

## Verification
The hardest state to reach from the ports is a replayed row whose stored slots have been overwritten. The row must run longer than the line buffer, so the saturated last slot keeps only the final pixel. The stimulus therefore uses a short buffer and writes a ten-pixel row into eight slots. It inserts a blank pixel to rewind the column and then replays the row, once at full and once at half intensity, while `pix_rgb` carries unrelated colours. The interrupt edge is driven by a run of blank pixels that switches vblank on, holds it, drops it and raises it again. This shows that only the first pixel of each vblank run raises the pin.

// File: rtl/vfmt_pkg.sv
package vfmt_pkg;

   typedef struct packed {
      logic hs;
      logic vs;
      logic hb;
      logic vb;
   } sync_t;

   localparam int SYNC_SLOTS = 4;

   typedef enum logic {
      FMT_DIRECT = 1'b0,
      FMT_SERIAL = 1'b1
   } fmt_e;

endpackage

// File: rtl/vfmt_phase.sv
module vfmt_phase #(
   parameter int PIX_CLKS = 4,
   localparam int PH_W    = $clog2(PIX_CLKS)
) (
   input  logic            clk,
   input  logic            rst_n,
   output logic [PH_W-1:0] ph,
   output logic            take
);

   localparam logic [PH_W-1:0] PH_LAST = PH_W'(PIX_CLKS - 1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph <= '0;
      end else if (ph == PH_LAST) begin
         ph <= '0;
      end else begin
         ph <= ph + 1'b1;
      end
   end

   assign take = (ph == PH_LAST);

endmodule

// File: rtl/vfmt_linebuf.sv
module vfmt_linebuf #(
   parameter int CH_W     = 4,
   parameter int LINE_PIX = 320,
   localparam int RGB_W   = 3 * CH_W,
   localparam int COL_W   = (LINE_PIX > 1) ? $clog2(LINE_PIX) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take,
   input  logic             blank,
   input  logic             dbl_row,
   input  logic             dim_en,
   input  logic [RGB_W-1:0] rgb_in,
   output logic [RGB_W-1:0] rgb_src
);

   localparam logic [COL_W-1:0] COL_LAST = COL_W'(LINE_PIX - 1);

   logic [COL_W-1:0] col;
   logic [RGB_W-1:0] mem [LINE_PIX];
   logic [RGB_W-1:0] replay;
   logic [RGB_W-1:0] raw;
   logic             darken;

   // column tracking: rewinds on blank, saturates at the last slot
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         col <= '0;
      end else if (take) begin
         if (blank) begin
            col <= '0;
         end else if (col != COL_LAST) begin
            col <= col + 1'b1;
         end
      end
   end

   // the first copy of a row fills the buffer
   always_ff @(posedge clk) begin
      if (take && !blank && !dbl_row) begin
         mem[col] <= rgb_in;
      end
   end

   assign replay = mem[col];
   assign raw    = dbl_row ? replay : rgb_in;
   assign darken = dbl_row && dim_en;

   for (genvar c = 0; c < 3; c++) begin : g_chan
      logic [CH_W-1:0] chan;
      assign chan = raw[c*CH_W +: CH_W];
      assign rgb_src[c*CH_W +: CH_W] = darken ? (chan >> 1) : chan;
   end

endmodule

// File: rtl/vfmt_pins.sv
module vfmt_pins
   import vfmt_pkg::*;
#(
   parameter int CH_W        = 4,
   parameter int DIRECT_BITS = 2,
   localparam int PH_W       = $clog2(CH_W),
   localparam int RGB_W      = 3 * CH_W,
   localparam int PINS       = 3 * DIRECT_BITS + 2
) (
   input  logic             mode_ser,
   input  logic [PH_W-1:0]  ph,
   input  logic [RGB_W-1:0] rgb,
   input  sync_t            sy,
   input  logic             irq,
   output logic [PINS-1:0]  pins
);

   localparam logic [PH_W-1:0] PH_LAST = PH_W'(CH_W - 1);

   logic [PINS-1:0] direct_w;
   logic [PINS-1:0] serial_w;
   logic [2:0]      ser_col;
   logic [PH_W-1:0] bit_sel;
   logic [CH_W-1:0] sync_slots;

   assign bit_sel = PH_LAST - ph;

   // sync flags occupy the leading slots, sent first-slot-first
   always_comb begin
      sync_slots = '0;
      sync_slots[CH_W-1 -: SYNC_SLOTS] = {sy.hs, sy.vs, sy.hb, sy.vb};
   end

   for (genvar c = 0; c < 3; c++) begin : g_chan
      logic [CH_W-1:0] chan;
      assign chan = rgb[c*CH_W +: CH_W];
      assign direct_w[c*DIRECT_BITS +: DIRECT_BITS] = chan[CH_W-1 -: DIRECT_BITS];
      assign ser_col[c] = chan[bit_sel];
   end

   assign direct_w[3*DIRECT_BITS]     = sy.vs;
   assign direct_w[3*DIRECT_BITS + 1] = sy.hs;

   always_comb begin
      serial_w      = '0;
      serial_w[2:0] = ser_col;
      serial_w[3]   = sync_slots[bit_sel];
      serial_w[4]   = ~ph[0];
      serial_w[5]   = (ph == PH_LAST);
      serial_w[6]   = irq;
   end

   assign pins = (fmt_e'(mode_ser) == FMT_SERIAL) ? serial_w : direct_w;

endmodule

// File: rtl/vfmt_top.sv
module vfmt_top
   import vfmt_pkg::*;
#(
   parameter int CH_W        = 4,
   parameter int PIX_CLKS    = 4,
   parameter int DIRECT_BITS = 2,
   parameter int LINE_PIX    = 320,
   localparam int RGB_W      = 3 * CH_W,
   localparam int PINS       = 3 * DIRECT_BITS + 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mode_ser,
   input  logic             dim_en,
   input  logic             dbl_row,
   input  logic [RGB_W-1:0] pix_rgb,
   input  logic             hs_in,
   input  logic             vs_in,
   input  logic             hb_in,
   input  logic             vb_in,
   output logic             pix_next,
   output logic [PINS-1:0]  vid_pins
);

   localparam int PH_W = $clog2(PIX_CLKS);

   if (PIX_CLKS != CH_W) begin : g_bad_clks
      $error("vfmt_top: PIX_CLKS must equal CH_W");
   end
   if (CH_W < SYNC_SLOTS) begin : g_bad_ch
      $error("vfmt_top: CH_W must cover the sync slots");
   end
   if (DIRECT_BITS < 1 || DIRECT_BITS > CH_W || PINS < 8) begin : g_bad_pins
      $error("vfmt_top: DIRECT_BITS out of range");
   end
   if (LINE_PIX < 2) begin : g_bad_line
      $error("vfmt_top: LINE_PIX too small");
   end

   logic [PH_W-1:0]  ph;
   logic             take;
   logic             blank;
   logic [RGB_W-1:0] src_rgb;
   sync_t            cur_sync;
   logic [RGB_W-1:0] cur_rgb;
   logic             irq_q;

   assign blank = hb_in | vb_in;

   vfmt_phase #(.PIX_CLKS(PIX_CLKS)) u_phase (
      .clk  (clk),
      .rst_n(rst_n),
      .ph   (ph),
      .take (take)
   );

   vfmt_linebuf #(.CH_W(CH_W), .LINE_PIX(LINE_PIX)) u_buf (
      .clk    (clk),
      .rst_n  (rst_n),
      .take   (take),
      .blank  (blank),
      .dbl_row(dbl_row),
      .dim_en (dim_en),
      .rgb_in (pix_rgb),
      .rgb_src(src_rgb)
   );

   // pixel register: loaded once per pixel period
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_sync <= '0;
         cur_rgb  <= '0;
         irq_q    <= 1'b0;
      end else if (take) begin
         cur_sync <= '{hs: hs_in, vs: vs_in, hb: hb_in, vb: vb_in};
         cur_rgb  <= blank ? '0 : src_rgb;
         irq_q    <= vb_in & ~cur_sync.vb;
      end
   end

   vfmt_pins #(.CH_W(CH_W), .DIRECT_BITS(DIRECT_BITS)) u_pins (
      .mode_ser(mode_ser),
      .ph      (ph),
      .rgb     (cur_rgb),
      .sy      (cur_sync),
      .irq     (irq_q),
      .pins    (vid_pins)
   );

   assign pix_next = take;

endmodule

// File: rtl/vfmt_checker.sv
module vfmt_checker #(
   parameter int PINS = 8
) (
   input logic            clk,
   input logic            rst_n,
   input logic            mode_ser,
   input logic            pix_next,
   input logic [PINS-1:0] vid_pins
);

   p_next_period_r1: assert property (@(posedge clk) disable iff (!rst_n)
      pix_next |=> !pix_next ##1 !pix_next ##1 !pix_next ##1 pix_next);

   p_capture_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
      mode_ser |-> (vid_pins[5] == pix_next));

   p_bitclk_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_ser && pix_next) |-> !vid_pins[4]);

   p_top_pin_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      mode_ser |-> !vid_pins[PINS-1]);

   p_direct_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_ser && !$past(mode_ser) && !$past(pix_next)) |-> $stable(vid_pins));

   p_irq_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_ser && $past(mode_ser) && $rose(vid_pins[6])) |-> $past(pix_next));

endmodule

bind vfmt_top vfmt_checker #(.PINS(PINS)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .mode_ser(mode_ser),
   .pix_next(pix_next),
   .vid_pins(vid_pins)
);

// File: tb/tb_vfmt_top.sv
module tb_vfmt_top;

   localparam int CLK_P = 10;
   localparam int LINE  = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mode_ser = 1'b0;
   logic        dim_en = 1'b0;
   logic        dbl_row = 1'b0;
   logic [11:0] pix_rgb = '0;
   logic        hs_in = 1'b0, vs_in = 1'b0, hb_in = 1'b0, vb_in = 1'b0;
   logic        pix_next;
   logic [7:0]  vid_pins;

   int total = 0;
   int bad   = 0;

   logic [7:0] exp_q[$];
   string      tag_q[$];

   // independent model state
   logic [11:0] bmem [LINE];
   int          bcol = 0;
   logic        bprev_vb = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   vfmt_top #(.LINE_PIX(LINE)) dut (
      .clk(clk), .rst_n(rst_n), .mode_ser(mode_ser), .dim_en(dim_en),
      .dbl_row(dbl_row), .pix_rgb(pix_rgb), .hs_in(hs_in), .vs_in(vs_in),
      .hb_in(hb_in), .vb_in(vb_in), .pix_next(pix_next), .vid_pins(vid_pins)
   );

   task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [7:0] word(logic ser, int k, logic [11:0] c,
                                       logic hs, logic vs, logic hb, logic vb,
                                       logic irq);
      logic [7:0] w;
      logic [3:0] sv;
      sv = {hs, vs, hb, vb};
      if (!ser) begin
         w = {hs, vs, c[11:10], c[7:6], c[3:2]};
      end else begin
         w    = '0;
         w[0] = c[3-k];
         w[1] = c[7-k];
         w[2] = c[11-k];
         w[3] = sv[3-k];
         w[4] = (k % 2 == 0);
         w[5] = (k == 3);
         w[6] = irq;
      end
      return w;
   endfunction

   // driver: call at a falling edge; drives one pixel and queues its 4 words
   task automatic send(string tag, logic [11:0] c, logic hs, logic vs,
                       logic hb, logic vb);
      logic [11:0] shown;
      logic        irq;
      while (!pix_next) @(negedge clk);
      pix_rgb = c; hs_in = hs; vs_in = vs; hb_in = hb; vb_in = vb;
      if (hb || vb) begin
         shown = '0;
      end else if (dbl_row) begin
         shown = bmem[bcol];
         if (dim_en) shown = {shown[11:8] >> 1, shown[7:4] >> 1, shown[3:0] >> 1};
      end else begin
         shown = c;
         bmem[bcol] = c;
      end
      if (hb || vb) bcol = 0;
      else if (bcol < LINE - 1) bcol++;
      irq = vb && !bprev_vb;
      bprev_vb = vb;
      for (int k = 0; k < 4; k++) begin
         exp_q.push_back(word(mode_ser, k, shown, hs, vs, hb, vb, irq));
         tag_q.push_back(tag);
      end
      repeat (4) @(negedge clk);
   endtask

   // monitor: compares one word per clock, a quarter period after the edge
   always @(posedge clk) begin
      #(CLK_P/4);
      if (exp_q.size() > 0) begin
         check(tag_q.pop_front(), vid_pins, exp_q.pop_front());
      end
   end

   initial begin
      #(CLK_P * 100000);
      bad++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int pulses;
      // R12: reset state
      repeat (3) @(negedge clk);
      check("R12 pins in reset", vid_pins, 8'h00);
      check("R12 pix_next in reset", {7'd0, pix_next}, 8'h00);
      rst_n = 1'b1;

      // R1: one pix_next per four clocks, first on the fourth clock
      pulses = 0;
      for (int i = 0; i < 16; i++) begin
         if (pix_next) pulses++;
         if (i == 3) check("R1 first strobe", {7'd0, pix_next}, 8'h01);
         @(negedge clk);
      end
      check("R1 strobe count", 8'(pulses), 8'd4);

      // R2, R3, R8: direct format
      mode_ser = 1'b0;
      send("R8 direct blank", 12'hFFF, 1, 1, 1, 1);
      send("R2 direct", 12'hC5A, 1, 0, 0, 0);
      send("R3 direct", 12'h3F0, 0, 1, 0, 0);
      send("R2 direct", 12'hA96, 0, 0, 0, 0);
      send("R8 direct hblank", 12'h777, 0, 1, 1, 0);

      // R4, R5, R6, R8: serial format
      mode_ser = 1'b1;
      send("R8 serial blank", 12'hEEE, 1, 0, 1, 0);
      send("R4 serial", 12'h9C3, 0, 0, 0, 0);
      send("R5 serial sync", 12'h5A6, 0, 1, 0, 0);
      send("R6 serial", 12'h18E, 1, 1, 0, 0);

      // R7: interrupt on the first pixel of each vblank run
      send("R7 active", 12'h321, 0, 0, 0, 0);
      send("R7 vb start", 12'h321, 0, 1, 0, 1);
      send("R7 vb hold", 12'h321, 0, 1, 0, 1);
      send("R7 vb end", 12'h321, 0, 0, 1, 0);
      send("R7 vb again", 12'h321, 0, 0, 0, 1);

      // R9, R10: fill, replay, replay dimmed
      send("R11 rewind", 12'h000, 0, 0, 1, 0);
      dbl_row = 1'b0;
      send("R9 fill", 12'h123, 0, 0, 0, 0);
      send("R9 fill", 12'h456, 0, 0, 0, 0);
      send("R9 fill", 12'h789, 0, 0, 0, 0);
      send("R9 fill", 12'hABC, 0, 0, 0, 0);
      send("R9 fill", 12'hDEF, 0, 0, 0, 0);
      send("R11 rewind", 12'h000, 0, 0, 1, 0);
      dbl_row = 1'b1;
      for (int i = 0; i < 5; i++) send("R9 replay", 12'hF0F, 0, 0, 0, 0);
      send("R11 rewind", 12'h000, 0, 0, 1, 0);
      dim_en = 1'b1;
      for (int i = 0; i < 5; i++) send("R10 dim replay", 12'h0F0, 0, 0, 0, 0);
      send("R11 rewind", 12'h000, 0, 0, 1, 0);

      // R11: over-long row saturates the column
      dbl_row = 1'b0; dim_en = 1'b0;
      for (int i = 0; i < 10; i++) send("R11 long fill", 12'(12'h210 + i * 12'h013), 0, 0, 0, 0);
      send("R11 rewind", 12'h000, 0, 0, 1, 0);
      dbl_row = 1'b1;
      for (int i = 0; i < 10; i++) send("R11 long replay", 12'h5A5, 0, 0, 0, 0);
      dim_en = 1'b1;
      send("R11 rewind", 12'h000, 0, 0, 1, 0);
      for (int i = 0; i < 3; i++) send("R10 dim long", 12'h000, 0, 0, 0, 0);

      repeat (3) @(negedge clk);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule